// File: doc/BRIEF.md
# Platform System I/O Register Block

This block is a small register file that sits on a byte-wide, port-mapped I/O path of a system board. It decodes a fixed set of single-byte I/O addresses. Behind those addresses are read/write control registers, read-only strapping values, a constant-zero status byte and a few write-only registers that accept data and keep nothing. Two of the writable registers drive side-band outputs. One is a processor soft-reset line. The other selects the non-contiguous I/O map mode, and it comes out of reset already asserted.

A separate select input opens a 4-byte parity-error status window. The window only accepts 32-bit accesses. It reads as zero, and every write to it counts as an invalid access. A sticky halt indication reports a request for the unsupported little-endian mode. An access-error pulse reports writes that land nowhere and accesses to the window that break its rules.

Inside each register byte, bits are numbered from the most significant end. Architectural bit n is data bit 7-n, so architectural bit 7 is data bit 0.

Top module: `sysio_regblock`

## Requirements
- R1: After a synchronous reset, softReset is 0, leHalt is 0 and mapNonContig is 1. Reads of address 0x092 and 0x81C return 0x00, and a read of 0x850 returns 0x01.
- R2: A write to 0x092 stores only data bit 0. softReset equals the stored bit from the cycle after the write edge, and a read of 0x092 returns 0x00 or 0x01.
- R3: A write to 0x092 with data bit 1 set (the little-endian request) sets leHalt. leHalt then stays set until reset.
- R4: A write to 0x81C stores the written byte ANDed with 0xF0 (data bits 7..4), and a read of 0x81C returns that value.
- R5: A write to 0x850 stores only data bit 0. mapNonContig follows the stored bit from the cycle after the write edge, and a read of 0x850 returns it.
- R6: Reads of 0x80C return the equipCfg input, and reads of 0x852 return the boardIdCfg input.
- R7: A read of 0x818 always returns 0x00.
- R8: Writes to 0x808, 0x810, 0x812 and 0x814 raise no accErr and change no readable register or side-band output.
- R9: A read of a write-only or unmapped address returns 0xFF and raises no accErr.
- R10: A write to a read-only or unmapped address changes no state, and accErr goes high for exactly the one cycle after the write edge.
- R11: With parSel high, a read with accWide=1 returns 0x00 without error. A read with accWide=0 returns 0xFF and pulses accErr. Any write pulses accErr and changes no state.
- R12: rdValid and rdData appear in the cycle after the rdStb edge. rdValid is low in every cycle that does not follow a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ioAddr | input | 12 | Byte I/O address |
| wrData | input | 8 | Write data |
| rdStb | input | 1 | Read strobe, one cycle per access |
| wrStb | input | 1 | Write strobe, one cycle per access |
| parSel | input | 1 | Access targets the parity-error window |
| accWide | input | 1 | Access size is 32 bits (parity window only) |
| equipCfg | input | 8 | Equipment strapping value |
| boardIdCfg | input | 8 | Board identification strapping value |
| rdData | output | 8 | Read data, registered |
| rdValid | output | 1 | Read data valid, one cycle |
| accErr | output | 1 | Invalid-access pulse |
| softReset | output | 1 | Processor soft-reset line |
| mapNonContig | output | 1 | Non-contiguous I/O map select |
| leHalt | output | 1 | Sticky unsupported-mode halt indication |

## Verification
Every result of this block is due one clock edge after the strobe that causes it. Register contents and the two side-band lines are updated on the edge that samples wrStb. rdData, rdValid and accErr are registered on the edge that samples the strobe. The bench drives strobes on the falling edge, lets one rising edge pass and checks on the following falling edge. For the pulse checks it also looks one further cycle on, to confirm that accErr and rdValid have dropped. Each claim that a write is ignored is checked through a later read-back and through the side-band pins.

// File: rtl/sysio_pkg.sv
package sysio_pkg;

  // Port addresses (fixed by the board's I/O map)
  localparam int AdrSreset   = 'h092;
  localparam int AdrLight    = 'h808;
  localparam int AdrEquip    = 'h80C;
  localparam int AdrPass1    = 'h810;
  localparam int AdrPass2    = 'h812;
  localparam int AdrCacheInv = 'h814;
  localparam int AdrKeylock  = 'h818;
  localparam int AdrSysCtl   = 'h81C;
  localparam int AdrMapType  = 'h850;
  localparam int AdrBoardId  = 'h852;

  // Architectural (MSB-first) bit numbers
  localparam int ArchSreset  = 7;
  localparam int ArchLeMode  = 6;
  localparam int ArchMapBit  = 7;
  localparam int ArchCtlLast = 3;   // bits 0..ArchCtlLast are kept

  typedef enum logic [2:0] {
    SRC_NONE, SRC_SRESET, SRC_EQUIP, SRC_KEYLOCK,
    SRC_SYSCTL, SRC_MAPTYPE, SRC_BOARDID, SRC_PARITY
  } rdSrc_e;

  typedef struct packed {
    logic   wrSreset;
    logic   wrSysCtl;
    logic   wrMapType;
    logic   rdEn;
    rdSrc_e rdSrc;
    logic   errHit;
  } ctrlStb_t;

endpackage

// File: rtl/sysio_ctrl.sv
module sysio_ctrl
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              parSel,
  input  logic              accWide,
  output ctrlStb_t          stb
);

  localparam int NumWo = 4;
  localparam int WoList [NumWo] = '{AdrLight, AdrPass1, AdrPass2, AdrCacheInv};

  logic [NumWo-1:0] woHit;

  for (genvar i = 0; i < NumWo; i++) begin : g_wo
    assign woHit[i] = (ioAddr == ADDR_W'(WoList[i]));
  end

  always_comb begin
    stb       = '0;
    stb.rdSrc = SRC_NONE;
    if (parSel) begin
      if (rdStb) begin
        stb.rdEn = 1'b1;
        if (accWide) stb.rdSrc = SRC_PARITY;
        else         stb.errHit = 1'b1;
      end
      if (wrStb) stb.errHit = 1'b1;
    end else begin
      if (wrStb) begin
        if      (ioAddr == ADDR_W'(AdrSreset))  stb.wrSreset  = 1'b1;
        else if (ioAddr == ADDR_W'(AdrSysCtl))  stb.wrSysCtl  = 1'b1;
        else if (ioAddr == ADDR_W'(AdrMapType)) stb.wrMapType = 1'b1;
        else if (!(|woHit))                     stb.errHit    = 1'b1;
      end
      if (rdStb) begin
        stb.rdEn = 1'b1;
        if      (ioAddr == ADDR_W'(AdrSreset))  stb.rdSrc = SRC_SRESET;
        else if (ioAddr == ADDR_W'(AdrEquip))   stb.rdSrc = SRC_EQUIP;
        else if (ioAddr == ADDR_W'(AdrKeylock)) stb.rdSrc = SRC_KEYLOCK;
        else if (ioAddr == ADDR_W'(AdrSysCtl))  stb.rdSrc = SRC_SYSCTL;
        else if (ioAddr == ADDR_W'(AdrMapType)) stb.rdSrc = SRC_MAPTYPE;
        else if (ioAddr == ADDR_W'(AdrBoardId)) stb.rdSrc = SRC_BOARDID;
      end
    end
  end

endmodule

// File: rtl/sysio_datapath.sv
module sysio_datapath
  import sysio_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStb_t          stb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] equipCfg,
  input  logic [DATA_W-1:0] boardIdCfg,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              accErr,
  output logic              softReset,
  output logic              mapNonContig,
  output logic              leHalt
);

  // MSB-first architectural bit n lives at data index DATA_W-1-n
  localparam int SresetIdx = DATA_W - 1 - ArchSreset;
  localparam int LeIdx     = DATA_W - 1 - ArchLeMode;
  localparam int MapIdx    = DATA_W - 1 - ArchMapBit;

  logic [DATA_W-1:0] ctlMask;
  for (genvar n = 0; n < DATA_W; n++) begin : g_mask
    assign ctlMask[DATA_W-1-n] = (n <= ArchCtlLast);
  end

  logic              sresetBit;
  logic              mapBit;
  logic              leSticky;
  logic [DATA_W-1:0] sysCtl;
  logic [DATA_W-1:0] rdMux;

  always_comb begin
    rdMux = '1;
    case (stb.rdSrc)
      SRC_SRESET:  begin rdMux = '0; rdMux[SresetIdx] = sresetBit; end
      SRC_EQUIP:   rdMux = equipCfg;
      SRC_KEYLOCK: rdMux = '0;
      SRC_SYSCTL:  rdMux = sysCtl;
      SRC_MAPTYPE: begin rdMux = '0; rdMux[MapIdx] = mapBit; end
      SRC_BOARDID: rdMux = boardIdCfg;
      SRC_PARITY:  rdMux = '0;
      default:     rdMux = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sresetBit <= 1'b0;
      leSticky  <= 1'b0;
      sysCtl    <= '0;
      mapBit    <= 1'b1;
      rdData    <= '0;
      rdValid   <= 1'b0;
      accErr    <= 1'b0;
    end else begin
      if (stb.wrSreset) begin
        sresetBit <= wrData[SresetIdx];
        if (wrData[LeIdx]) leSticky <= 1'b1;
      end
      if (stb.wrSysCtl)  sysCtl <= wrData & ctlMask;
      if (stb.wrMapType) mapBit <= wrData[MapIdx];
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= rdMux;
      accErr  <= stb.errHit;
    end
  end

  assign softReset    = sresetBit;
  assign mapNonContig = mapBit;
  assign leHalt       = leSticky;

  a_r2_sreset_latch: assert property (@(posedge clk) disable iff (rst)
    stb.wrSreset |=> softReset == $past(wrData[SresetIdx]));
  a_r3_le_set: assert property (@(posedge clk) disable iff (rst)
    (stb.wrSreset && wrData[LeIdx]) |=> leHalt);
  a_r3_le_sticky: assert property (@(posedge clk) disable iff (rst)
    leHalt |=> leHalt);
  a_r4_sysctl_mask: assert property (@(posedge clk) disable iff (rst)
    stb.wrSysCtl |=> sysCtl == ($past(wrData) & ctlMask));
  a_r5_map_follow: assert property (@(posedge clk) disable iff (rst)
    stb.wrMapType |=> mapNonContig == $past(wrData[MapIdx]));
  a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
    stb.errHit |=> accErr);
  a_r12_rd_valid: assert property (@(posedge clk) disable iff (rst)
    stb.rdEn |=> rdValid);
  a_r12_rd_idle: assert property (@(posedge clk) disable iff (rst)
    !stb.rdEn |=> !rdValid);

endmodule

// File: rtl/sysio_regblock.sv
module sysio_regblock
  import sysio_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdStb,
  input  logic              wrStb,
  input  logic              parSel,
  input  logic              accWide,
  input  logic [DATA_W-1:0] equipCfg,
  input  logic [DATA_W-1:0] boardIdCfg,
  output logic [DATA_W-1:0] rdData,
  output logic              rdValid,
  output logic              accErr,
  output logic              softReset,
  output logic              mapNonContig,
  output logic              leHalt
);

  ctrlStb_t stb;

  sysio_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .ioAddr (ioAddr),
    .rdStb  (rdStb),
    .wrStb  (wrStb),
    .parSel (parSel),
    .accWide(accWide),
    .stb    (stb)
  );

  sysio_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rst         (rst),
    .stb         (stb),
    .wrData      (wrData),
    .equipCfg    (equipCfg),
    .boardIdCfg  (boardIdCfg),
    .rdData      (rdData),
    .rdValid     (rdValid),
    .accErr      (accErr),
    .softReset   (softReset),
    .mapNonContig(mapNonContig),
    .leHalt      (leHalt)
  );

endmodule

// File: tb/sysio_regblock_bench.sv
module sysio_regblock_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] ioAddr;
  logic [7:0]  wrData;
  logic        rdStb, wrStb, parSel, accWide;
  logic [7:0]  equipCfg, boardIdCfg;
  logic [7:0]  rdData;
  logic        rdValid, accErr, softReset, mapNonContig, leHalt;

  int nTests = 0;
  int nFail  = 0;

  always #10 clk = ~clk;  // 50 MHz

  sysio_regblock u_sysio_regblock (
    .clk(clk), .rst(rst), .ioAddr(ioAddr), .wrData(wrData),
    .rdStb(rdStb), .wrStb(wrStb), .parSel(parSel), .accWide(accWide),
    .equipCfg(equipCfg), .boardIdCfg(boardIdCfg), .rdData(rdData),
    .rdValid(rdValid), .accErr(accErr), .softReset(softReset),
    .mapNonContig(mapNonContig), .leHalt(leHalt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Drive a write for one cycle; on return, the cycle after the write edge.
  task automatic doWrite(input logic [11:0] a, input logic [7:0] d,
                         input logic par = 1'b0, input logic wide = 1'b0);
    @(negedge clk);
    ioAddr = a; wrData = d; parSel = par; accWide = wide; wrStb = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; parSel = 1'b0; accWide = 1'b0;
  endtask

  // Read; returns data, valid and error seen in the cycle after the edge.
  task automatic doRead(input logic [11:0] a, output logic [7:0] d,
                        output logic v, output logic e,
                        input logic par = 1'b0, input logic wide = 1'b0);
    @(negedge clk);
    ioAddr = a; parSel = par; accWide = wide; rdStb = 1'b1;
    @(negedge clk);
    rdStb = 1'b0; parSel = 1'b0; accWide = 1'b0;
    d = rdData; v = rdValid; e = accErr;
  endtask

  task automatic applyReset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] d; logic v, e;
    applyReset();
    check("R1 softReset", softReset, 0);
    check("R1 mapNonContig", mapNonContig, 1);
    check("R1 leHalt", leHalt, 0);
    check("R12 rdValid idle", rdValid, 0);
    doRead(12'h092, d, v, e); check("R1 rd 092", d, 8'h00);
    doRead(12'h81C, d, v, e); check("R1 rd 81C", d, 8'h00);
    doRead(12'h850, d, v, e); check("R1 rd 850", d, 8'h01);
  endtask

  task automatic testSreset();
    logic [7:0] d; logic v, e;
    doWrite(12'h092, 8'hFD);
    check("R2 softReset set", softReset, 1);
    check("R3 no le", leHalt, 0);
    doRead(12'h092, d, v, e);
    check("R2 rd 092", d, 8'h01);
    check("R12 rdValid", v, 1);
    @(negedge clk);
    check("R12 rdValid drops", rdValid, 0);
    doWrite(12'h092, 8'hFC);
    check("R2 softReset clear", softReset, 0);
    doRead(12'h092, d, v, e); check("R2 rd 092 clear", d, 8'h00);
  endtask

  task automatic testLeMode();
    doWrite(12'h092, 8'h03);
    check("R3 leHalt set", leHalt, 1);
    check("R2 sreset with le", softReset, 1);
    doWrite(12'h092, 8'h00);
    check("R3 leHalt sticky", leHalt, 1);
    applyReset();
    check("R3 leHalt reset", leHalt, 0);
  endtask

  task automatic testSysCtl();
    logic [7:0] d; logic v, e;
    doWrite(12'h81C, 8'hFF);
    doRead(12'h81C, d, v, e); check("R4 mask FF", d, 8'hF0);
    doWrite(12'h81C, 8'hA5);
    doRead(12'h81C, d, v, e); check("R4 mask A5", d, 8'hA0);
  endtask

  task automatic testMapType();
    logic [7:0] d; logic v, e;
    doWrite(12'h850, 8'hFE);
    check("R5 map out low", mapNonContig, 0);
    doRead(12'h850, d, v, e); check("R5 rd 850 low", d, 8'h00);
    doWrite(12'h850, 8'h81);
    check("R5 map out high", mapNonContig, 1);
    doRead(12'h850, d, v, e); check("R5 rd 850 high", d, 8'h01);
  endtask

  task automatic testStatic();
    logic [7:0] d; logic v, e;
    equipCfg = 8'h5A; boardIdCfg = 8'hC3;
    doRead(12'h80C, d, v, e); check("R6 equip", d, 8'h5A);
    doRead(12'h852, d, v, e); check("R6 board id", d, 8'hC3);
    equipCfg = 8'h00;
    doRead(12'h80C, d, v, e); check("R6 equip zero", d, 8'h00);
    doRead(12'h818, d, v, e); check("R7 keylock", d, 8'h00);
  endtask

  task automatic testWriteOnly();
    logic [7:0] d; logic v, e;
    doWrite(12'h81C, 8'h50);
    for (int i = 0; i < 4; i++) begin
      logic [11:0] a;
      a = (i == 0) ? 12'h808 : (i == 1) ? 12'h810 : (i == 2) ? 12'h812 : 12'h814;
      doWrite(a, 8'hFF);
      check("R8 no err", accErr, 0);
      doRead(a, d, v, e);
      check("R9 wo read FF", d, 8'hFF);
      check("R9 wo read no err", e, 0);
    end
    check("R8 softReset kept", softReset, 0);
    check("R8 map kept", mapNonContig, 1);
    doRead(12'h81C, d, v, e); check("R8 sysctl kept", d, 8'h50);
    doRead(12'h400, d, v, e); check("R9 unmapped FF", d, 8'hFF);
    check("R9 unmapped no err", e, 0);
  endtask

  task automatic testBadWrite();
    logic [7:0] d; logic v, e;
    doWrite(12'h80C, 8'h01);
    check("R10 ro err pulse", accErr, 1);
    @(negedge clk);
    check("R10 err one cycle", accErr, 0);
    doWrite(12'h123, 8'h01);
    check("R10 unmapped err", accErr, 1);
    doWrite(12'h852, 8'h01);
    check("R10 board err", accErr, 1);
    check("R10 softReset kept", softReset, 0);
    check("R10 map kept", mapNonContig, 1);
    doRead(12'h81C, d, v, e); check("R10 sysctl kept", d, 8'h50);
  endtask

  task automatic testParity();
    logic [7:0] d; logic v, e;
    doRead(12'h092, d, v, e, 1'b1, 1'b1);
    check("R11 wide read zero", d, 8'h00);
    check("R11 wide read no err", e, 0);
    check("R11 wide read valid", v, 1);
    doRead(12'h092, d, v, e, 1'b1, 1'b0);
    check("R11 narrow read FF", d, 8'hFF);
    check("R11 narrow read err", e, 1);
    doWrite(12'h092, 8'h01, 1'b1, 1'b1);
    check("R11 write err", accErr, 1);
    check("R11 write no sreset", softReset, 0);
  endtask

  initial begin
    rst = 1'b1; ioAddr = '0; wrData = '0; rdStb = 1'b0; wrStb = 1'b0;
    parSel = 1'b0; accWide = 1'b0; equipCfg = 8'h00; boardIdCfg = 8'h00;
    testReset();
    testSreset();
    testLeMode();
    testSysCtl();
    testMapType();
    testStatic();
    testWriteOnly();
    testBadWrite();
    testParity();
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nTests++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule